// File: doc/BRIEF.md
# Microcoded Status Flag Update Unit

This block keeps the five status flags of an 8-bit accumulator datapath: sign, zero, auxiliary (half) carry, parity and carry. A microcode sequencer drives a 2-bit update selector, a clear-carries control, the 6-bit ALU operation code and two carry requests, one to set the carry and one to complement it. The ALU supplies its 8-bit result, its carry out and its half-carry out.

The controls are registered before they act. A microinstruction issued in cycle N selects the flag write. That write happens at the clock edge that ends cycle N+1 and uses the ALU outputs present during cycle N+1. This matches an ALU that works on operands latched by the microinstruction. The flags are presented as a packed status byte, and the stored carry is fed back to the ALU.

Top module: `psw_flag_unit`

## Requirements
- R1: While the synchronous active-high reset is applied, all five flags are cleared. After reset the status byte reads 8'h02 and `carry_o` is 0.
- R2: The status byte is laid out as bit7 = S, bit6 = Z, bit5 = 0, bit4 = AC, bit3 = 0, bit2 = P, bit1 = 1, bit0 = CY. The constant bits never change.
- R3: Controls issued in cycle N change nothing at the edge that ends cycle N. They update the flags at the edge that ends cycle N+1, using the ALU result, carry and half-carry present in cycle N+1.
- R4: Update selector 2'b00 leaves every flag unchanged.
- R5: Update selector 2'b01 loads CY from the ALU carry and leaves S, Z, AC and P unchanged.
- R6: Update selector 2'b10 loads S from result bit 7, Z from (result == 0), P from even parity of the result and AC from the ALU half-carry. CY is left unchanged.
- R7: Update selector 2'b11 loads S, Z, AC and P as in R6 and also loads CY from the ALU carry.
- R8: When the clear-carries control is set, CY becomes 0 and AC becomes 0. If the operation code is 6'b000100 (logic AND), AC becomes 1 instead. This holds with any update selector. S, Z and P still follow the selector.
- R9: A set-carry request makes CY equal to 1.
- R10: A complement-carry request inverts the stored CY.
- R11: For CY, the sources rank as follows, highest first: clear-carries, then set-carry, then complement-carry, then the update selector.
- R12: `carry_o` always equals the stored CY, which is bit 0 of the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_pat_i | input | 2 | Flag update selector from microcode |
| clr_acy_i | input | 1 | Clear-carries control |
| alu_op_i | input | 6 | ALU operation code of the microinstruction |
| set_cy_i | input | 1 | Set-carry request |
| cmc_i | input | 1 | Complement-carry request |
| alu_res_i | input | 8 | ALU result (one cycle after issue) |
| alu_cy_i | input | 1 | ALU carry out (one cycle after issue) |
| alu_hc_i | input | 1 | ALU half-carry out (one cycle after issue) |
| psw_o | output | 8 | Packed status byte |
| carry_o | output | 1 | Stored carry, returned to the ALU |

## Verification
Two things can happen in the same cycle. One microinstruction's delayed flag write takes effect while the next microinstruction's controls are being captured into the pipeline. To provoke this, the bench issues microinstructions on every consecutive cycle. In each cycle it drives the new controls together with the ALU data that belongs to the previous microinstruction. A scoreboard queues each expected status byte and the cycle it is due in. It then judges that the flags reflect only the older microinstruction's controls and data, for both logic-with-clear and arithmetic cases.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int DATA_W   = 8;
    localparam int OP_W     = 6;
    localparam int CTL_DLY  = 1;

    localparam logic [OP_W-1:0] OP_AND = 6'b000100;

    typedef enum logic [1:0] {
        PAT_HOLD  = 2'b00,
        PAT_CARRY = 2'b01,
        PAT_NOCY  = 2'b10,
        PAT_ALL   = 2'b11
    } flag_pat_e;

    typedef struct packed {
        flag_pat_e       pat;
        logic            clr_acy;
        logic [OP_W-1:0] op;
        logic            set_cy;
        logic            cmc;
    } ctl_t;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    localparam ctl_t   CTL_IDLE   = '{pat: PAT_HOLD, clr_acy: 1'b0, op: '0, set_cy: 1'b0, cmc: 1'b0};
    localparam flags_t FLAGS_ZERO = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b0};

    function automatic logic even_parity(input logic [DATA_W-1:0] v);
        return ~^v;
    endfunction

    function automatic logic [7:0] pack_psw(input flags_t f);
        return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
    endfunction

endpackage

// File: rtl/psw_ctl_pipe.sv
module psw_ctl_pipe
    import psw_pkg::*;
#(
    parameter int STAGES = CTL_DLY
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t d,
    output ctl_t q
);
    ctl_t stg [STAGES+1];

    assign stg[0] = d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i+1] <= CTL_IDLE;
                else     stg[i+1] <= stg[i];
            end
        end
    endgenerate

    assign q = stg[STAGES];
endmodule

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
    import psw_pkg::*;
(
    input  ctl_t              ctl,
    input  flags_t            cur,
    input  logic [DATA_W-1:0] res,
    input  logic              alu_cy,
    input  logic              alu_hc,
    output flags_t            nxt
);
    logic upd_main;
    logic upd_cy;

    always_comb begin
        upd_main = (ctl.pat == PAT_NOCY) || (ctl.pat == PAT_ALL);
        upd_cy   = (ctl.pat == PAT_CARRY) || (ctl.pat == PAT_ALL);

        nxt = cur;
        if (upd_main) begin
            nxt.s  = res[DATA_W-1];
            nxt.z  = (res == '0);
            nxt.p  = even_parity(res);
            nxt.ac = alu_hc;
        end

        if (ctl.clr_acy)
            nxt.ac = (ctl.op == OP_AND);

        if (ctl.clr_acy)      nxt.cy = 1'b0;
        else if (ctl.set_cy)  nxt.cy = 1'b1;
        else if (ctl.cmc)     nxt.cy = ~cur.cy;
        else if (upd_cy)      nxt.cy = alu_cy;
    end
endmodule

// File: rtl/psw_flag_reg.sv
module psw_flag_reg
    import psw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t nxt,
    output flags_t cur,
    output logic [7:0] psw
);
    always_ff @(posedge clk) begin
        if (rst) cur <= FLAGS_ZERO;
        else     cur <= nxt;
    end

    assign psw = pack_psw(cur);

    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        (psw[5] == 1'b0) && (psw[3] == 1'b0) && (psw[1] == 1'b1));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cur == FLAGS_ZERO));
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
    import psw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  flag_pat_i,
    input  logic        clr_acy_i,
    input  logic [5:0]  alu_op_i,
    input  logic        set_cy_i,
    input  logic        cmc_i,
    input  logic [7:0]  alu_res_i,
    input  logic        alu_cy_i,
    input  logic        alu_hc_i,
    output logic [7:0]  psw_o,
    output logic        carry_o
);
    ctl_t   ctl_in;
    ctl_t   ctl_q;
    flags_t cur;
    flags_t nxt;

    always_comb begin
        ctl_in.pat     = flag_pat_e'(flag_pat_i);
        ctl_in.clr_acy = clr_acy_i;
        ctl_in.op      = alu_op_i;
        ctl_in.set_cy  = set_cy_i;
        ctl_in.cmc     = cmc_i;
    end

    psw_ctl_pipe #(.STAGES(CTL_DLY)) u_pipe (
        .clk (clk),
        .rst (rst),
        .d   (ctl_in),
        .q   (ctl_q)
    );

    psw_flag_calc u_calc (
        .ctl    (ctl_q),
        .cur    (cur),
        .res    (alu_res_i),
        .alu_cy (alu_cy_i),
        .alu_hc (alu_hc_i),
        .nxt    (nxt)
    );

    psw_flag_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur),
        .psw (psw_o)
    );

    assign carry_o = cur.cy;

    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pat == PAT_HOLD && !ctl_q.clr_acy && !ctl_q.set_cy && !ctl_q.cmc)
        |=> $stable(psw_o));

    a_r6_cy_kept: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pat == PAT_NOCY && !ctl_q.clr_acy && !ctl_q.set_cy && !ctl_q.cmc)
        |=> $stable(carry_o));

    a_r8_and_sets_ac: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.clr_acy && ctl_q.op == OP_AND) |=> (psw_o[4] && !carry_o));

    a_r9_set_forces_cy: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.set_cy && !ctl_q.clr_acy) |=> carry_o);

    a_r10_cmc_inverts: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.cmc && !ctl_q.set_cy && !ctl_q.clr_acy) |=> (carry_o != $past(carry_o)));

    a_r12_carry_matches: assert property (@(posedge clk) disable iff (rst)
        carry_o == psw_o[0]);
endmodule

// File: tb/sim_psw_flag_unit.sv
`timescale 1ns/1ps
module sim_psw_flag_unit;

    typedef struct {
        logic [1:0] pat;
        logic       clr;
        logic [5:0] op;
        logic       setc;
        logic       cmc;
        logic [7:0] res;
        logic       c;
        logic       h;
        string      req;
    } item_t;

    typedef struct {
        logic [7:0] psw;
        int         due;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] flag_pat_i = 2'b00;
    logic       clr_acy_i = 1'b0;
    logic [5:0] alu_op_i = 6'd0;
    logic       set_cy_i = 1'b0;
    logic       cmc_i = 1'b0;
    logic [7:0] alu_res_i = 8'd0;
    logic       alu_cy_i = 1'b0;
    logic       alu_hc_i = 1'b0;
    logic [7:0] psw_o;
    logic       carry_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    item_t items[$];
    exp_t  sb[$];

    logic ms = 0, mz = 0, mac = 0, mp = 0, mcy = 0;

    localparam logic [5:0] OPC_ADD = 6'b000000;
    localparam logic [5:0] OPC_SUB = 6'b000010;
    localparam logic [5:0] OPC_AND = 6'b000100;
    localparam logic [5:0] OPC_OR  = 6'b000101;
    localparam logic [5:0] OPC_XOR = 6'b000110;

    always #2.5 clk = ~clk;

    psw_flag_unit u0 (
        .clk(clk), .rst(rst), .flag_pat_i(flag_pat_i), .clr_acy_i(clr_acy_i),
        .alu_op_i(alu_op_i), .set_cy_i(set_cy_i), .cmc_i(cmc_i),
        .alu_res_i(alu_res_i), .alu_cy_i(alu_cy_i), .alu_hc_i(alu_hc_i),
        .psw_o(psw_o), .carry_o(carry_o)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: psw actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] model_psw();
        return {ms, mz, 1'b0, mac, 1'b0, mp, 1'b1, mcy};
    endfunction

    task automatic model_step(input item_t it);
        logic main_u, cy_u;
        main_u = it.pat[1];
        cy_u   = (it.pat == 2'b01) || (it.pat == 2'b11);
        if (main_u) begin
            ms = it.res[7];
            mz = (it.res == 8'h00);
            mp = ~(^it.res);
            mac = it.h;
        end
        if (it.clr) mac = (it.op == OPC_AND);
        if (it.clr)       mcy = 1'b0;
        else if (it.setc) mcy = 1'b1;
        else if (it.cmc)  mcy = ~mcy;
        else if (cy_u)    mcy = it.c;
    endtask

    task automatic add(input logic [1:0] pat, input logic clr, input logic [5:0] op,
                       input logic setc, input logic cmc, input logic [7:0] res,
                       input logic c, input logic h, input string req);
        item_t it;
        it.pat = pat; it.clr = clr; it.op = op; it.setc = setc; it.cmc = cmc;
        it.res = res; it.c = c; it.h = h; it.req = req;
        items.push_back(it);
    endtask

    // Monitor: compares each queued expectation in its due cycle
    always @(negedge clk) begin
        if (!rst && sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, psw_o, e.psw);
            checks++;
            if (carry_o !== e.psw[0]) begin
                errors++;
                $display("FAIL R12: carry_o actual=%0b expected=%0b", carry_o, e.psw[0]);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        // directed items
        add(2'b11, 0, OPC_ADD, 0, 0, 8'h00, 1, 1, "R7");
        add(2'b11, 0, OPC_SUB, 0, 0, 8'hFF, 1, 0, "R7");
        add(2'b11, 1, OPC_AND, 0, 0, 8'h3C, 1, 0, "R8");
        add(2'b11, 1, OPC_OR,  0, 0, 8'h81, 1, 1, "R8");
        add(2'b11, 1, OPC_XOR, 0, 0, 8'h00, 1, 1, "R8");
        add(2'b00, 0, OPC_ADD, 1, 0, 8'h55, 0, 0, "R9");
        add(2'b10, 0, OPC_ADD, 0, 0, 8'h07, 0, 1, "R6");
        add(2'b01, 0, OPC_ADD, 0, 0, 8'h00, 0, 0, "R5");
        add(2'b00, 0, OPC_ADD, 0, 0, 8'hFF, 1, 1, "R4");
        add(2'b00, 0, OPC_ADD, 0, 1, 8'h00, 0, 0, "R10");
        add(2'b00, 0, OPC_ADD, 0, 1, 8'h00, 0, 0, "R10");
        add(2'b00, 1, OPC_ADD, 1, 0, 8'h00, 1, 1, "R11");
        add(2'b00, 0, OPC_ADD, 1, 1, 8'h00, 0, 0, "R11");
        add(2'b11, 0, OPC_ADD, 0, 1, 8'h10, 0, 0, "R11");
        add(2'b00, 1, OPC_AND, 0, 0, 8'h12, 1, 0, "R8");
        add(2'b10, 1, OPC_SUB, 0, 0, 8'h01, 1, 1, "R8");
        lf = 8'hA7;
        for (int i = 0; i < 24; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            add(lf[1:0], (i % 5 == 2), (i % 3 == 0) ? OPC_AND : OPC_ADD,
                (i % 7 == 3), (i % 4 == 1), lf ^ 8'h3D, lf[6], lf[2], "R7");
        end

        // reset phase
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", psw_o, 8'h02);
        rst = 1'b0;
        @(negedge clk);
        check("R2", psw_o, 8'h02);

        // latency: issue ALL with wrong data, then correct data next cycle
        flag_pat_i = 2'b11; alu_op_i = OPC_ADD; alu_res_i = 8'h00; alu_cy_i = 1; alu_hc_i = 1;
        @(negedge clk);
        check("R3", psw_o, 8'h02);
        flag_pat_i = 2'b00; alu_res_i = 8'h80; alu_cy_i = 0; alu_hc_i = 0;
        @(negedge clk);
        check("R3", psw_o, 8'h82);
        ms = 1; mz = 0; mac = 0; mp = 0; mcy = 0;

        // back-to-back stream: controls of item k with data of item k-1
        for (int k = 0; k <= items.size(); k++) begin
            @(negedge clk);
            if (k < items.size()) begin
                flag_pat_i = items[k].pat; clr_acy_i = items[k].clr; alu_op_i = items[k].op;
                set_cy_i = items[k].setc; cmc_i = items[k].cmc;
            end else begin
                flag_pat_i = 2'b00; clr_acy_i = 0; alu_op_i = 6'd0; set_cy_i = 0; cmc_i = 0;
            end
            if (k > 0) begin
                exp_t e;
                alu_res_i = items[k-1].res; alu_cy_i = items[k-1].c; alu_hc_i = items[k-1].h;
                model_step(items[k-1]);
                e.psw = model_psw(); e.due = cyc + 1; e.req = items[k-1].req;
                sb.push_back(e);
            end
        end
        repeat (4) @(negedge clk);
        check("R4", psw_o, model_psw());
        if (sb.size() != 0) begin
            errors++; checks++;
            $display("FAIL R3: pending actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule